// File: doc/BRIEF.md
# Memory Bus Wiring Test Engine

This block is a built-in self-test controller for the wiring between a chip and a simple synchronous SRAM-style memory. After a start pulse it takes over the memory port and runs two checks in a fixed order. The first is a walking-ones check of the data lines at one fixed address. The second is an aliasing check of the address lines over a power-of-two region. The address check is entered only when the data check is clean, because it relies on data travelling correctly.

The region is given by an aligned base address and the base-2 logarithm of its size in words. The controller touches only offset zero and the offsets with exactly one bit set below the region size, so address bits above the region stay at the value of the base. When it finishes, it raises a done flag and reports pass or fail. On a failure it gives a code for the failing phase and either the failing data pattern or the failing address. These results stay put until the next start pulse.

Top module: `membus_wiring_bist`

## Requirements
- R1: While reset is high and after it falls, done, pass, fail_stage and fail_info are 0, and neither mem_we nor mem_re is asserted until a start pulse.
- R2: The data check writes DATA_W patterns to base_addr, each with a single set bit, running from bit 0 up to the MSB. Each pattern is read back before the next one is written. At the first mismatch the run ends with pass=0, fail_stage=1 and fail_info set to that pattern, zero-extended.
- R3: When the data check fails, the port never accesses any address other than base_addr during that run.
- R4: Port addresses are base_addr OR an offset, where the offset is 0 or 2^j with j < size_lg. A size_lg above ADDR_W acts as ADDR_W. A fault confined to address bits above the region therefore does not cause a failure.
- R5: Background phase: the background word (odd bits set, 0xAA at 8 bits) goes to every 2^j offset. Its complement (0x55) then goes to offset 0, and every 2^j offset is read. A location not holding the background ends the run with fail_stage=2 and fail_info set to that location's address.
- R6: Walking phase: for each 2^j offset in ascending j, the complement is written there. Offset 0 and every other 2^j offset must then hold the background. A mismatch ends the run with fail_stage=3 and fail_info set to the address of the offset under test. Otherwise the background is put back at that offset.
- R7: A clean run ends with done=1, pass=1, fail_stage=0 and fail_info=0. Every location the address check touched then holds the background.
- R8: Results are held until the next start. A start while a run is in progress is ignored. A start accepted while idle clears done on the next clock edge.
- R9: The memory port is registered, and a read and a write are never driven in the same cycle. Read data is taken to be valid one cycle after mem_re is seen on the port, and it is compared exactly then.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle pulse that begins a run when idle |
| base_addr | input | ADDR_W | Region base, aligned to the region size |
| size_lg | input | $clog2(ADDR_W+1) | log2 of the region size in words |
| mem_rdata | input | DATA_W | Read data, one cycle after mem_re |
| mem_addr | output | ADDR_W | Memory address |
| mem_wdata | output | DATA_W | Memory write data |
| mem_we | output | 1 | Memory write strobe |
| mem_re | output | 1 | Memory read strobe |
| done | output | 1 | Run finished; held until next start |
| pass | output | 1 | Run finished with no mismatch |
| fail_stage | output | 2 | 0 none, 1 data check, 2 background phase, 3 walking phase |
| fail_info | output | max(ADDR_W,DATA_W) | Failing pattern or failing address |

## Verification
The bench builds the block with ADDR_W=8 and DATA_W=8. With these values every data pattern and every address bit, including the MSBs, can be reached by a behavioural memory with injectable faults: data bits stuck high or low, address bits stuck high or low, and OR-shorted address bits. Regions of 1, 16 and 256 words are run, plus a size_lg above ADDR_W. This shows that a fault outside the region is ignored and that each failure code comes from the phase the requirements assign to it.

// File: rtl/mbt_pkg.sv
package mbt_pkg;
  typedef enum logic [4:0] {
    ST_IDLE, ST_D_WR, ST_D_RD, ST_D_W1, ST_D_CMP,
    ST_A_FILL, ST_A_MARK, ST_A_RD, ST_A_W1, ST_A_CMP, ST_A_REST,
    ST_C_SET, ST_C_RD, ST_C_W1, ST_C_CMP, ST_C_REST
  } mbt_state_e;

  typedef enum logic [1:0] {
    FS_NONE = 2'd0,
    FS_DATA = 2'd1,
    FS_MARK = 2'd2,
    FS_WALK = 2'd3
  } mbt_stage_e;
endpackage

// File: rtl/mbt_port.sv
module mbt_port #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_we,
  input  logic              req_re,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              mem_we,
  output logic              mem_re
);
  always_ff @(posedge clk) begin
    if (rst) begin
      mem_addr  <= '0;
      mem_wdata <= '0;
      mem_we    <= 1'b0;
      mem_re    <= 1'b0;
    end else begin
      mem_addr  <= req_addr;
      mem_wdata <= req_wdata;
      mem_we    <= req_we;
      mem_re    <= req_re;
    end
  end

  // R9: the port never reads and writes in one cycle
  p_one_op_r9: assert property (@(posedge clk) disable iff (rst)
    !(mem_we && mem_re));
endmodule

// File: rtl/mbt_check.sv
module mbt_check #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_re,
  input  logic [DATA_W-1:0] req_exp,
  input  logic              mem_re,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              cmp_vld,
  output logic              cmp_bad
);
  logic              vld1, vld2;
  logic [DATA_W-1:0] exp1, exp2;

  always_ff @(posedge clk) begin
    if (rst) begin
      vld1 <= 1'b0;
      vld2 <= 1'b0;
      exp1 <= '0;
      exp2 <= '0;
    end else begin
      vld1 <= req_re;
      exp1 <= req_exp;
      vld2 <= vld1;
      exp2 <= exp1;
    end
  end

  assign cmp_vld = vld2;
  assign cmp_bad = vld2 && (mem_rdata != exp2);

  // R9: a compare is only offered one cycle after the port showed a read
  p_rd_latency_r9: assert property (@(posedge clk) disable iff (rst)
    cmp_vld |-> $past(mem_re));
endmodule

// File: rtl/mbt_ctrl.sv
module mbt_ctrl
  import mbt_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16,
  parameter int SW     = 5,
  parameter int IW     = 16,
  parameter int CW     = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [ADDR_W-1:0] base_addr,
  input  logic [SW-1:0]     size_lg,
  input  logic              cmp_vld,
  input  logic              cmp_bad,
  output logic              req_we,
  output logic              req_re,
  output logic [ADDR_W-1:0] req_addr,
  output logic [DATA_W-1:0] req_wdata,
  output logic [DATA_W-1:0] req_exp,
  output logic              done,
  output logic              pass,
  output mbt_stage_e        fail_stage,
  output logic [IW-1:0]     fail_info
);
  localparam int BW = $clog2(DATA_W + 1);

  function automatic logic [DATA_W-1:0] alt_pat();
    logic [DATA_W-1:0] p;
    for (int i = 0; i < DATA_W; i++) p[i] = (i % 2) == 1;
    return p;
  endfunction

  localparam logic [DATA_W-1:0] BG = alt_pat();
  localparam logic [DATA_W-1:0] MK = ~BG;

  function automatic logic [ADDR_W-1:0] slot_off(input logic [CW-1:0] k);
    if (k == '0) return '0;
    return ADDR_W'(1) << (k - CW'(1));
  endfunction

  mbt_state_e        state;
  logic [BW-1:0]     bit_i;
  logic [CW-1:0]     s_q, t_q, nb_q;
  logic [ADDR_W-1:0] base_q;
  logic [CW-1:0]     rslot;
  logic [DATA_W-1:0] walk_pat;
  logic              s_in, t_in;

  assign walk_pat = DATA_W'(1) << bit_i;
  assign s_in     = s_q <= nb_q;
  assign t_in     = t_q <= nb_q;

  always_comb begin
    req_we    = 1'b0;
    req_re    = 1'b0;
    rslot     = '0;
    req_wdata = '0;
    req_exp   = '0;
    unique case (state)
      ST_D_WR:   begin req_we = 1'b1; req_wdata = walk_pat; end
      ST_D_RD:   begin req_re = 1'b1; req_exp   = walk_pat; end
      ST_A_FILL: if (s_in) begin req_we = 1'b1; rslot = s_q; req_wdata = BG; end
      ST_A_MARK: begin req_we = 1'b1; req_wdata = MK; end
      ST_A_RD:   if (s_in) begin req_re = 1'b1; rslot = s_q; req_exp = BG; end
      ST_A_REST: begin req_we = 1'b1; req_wdata = BG; end
      ST_C_SET:  if (t_in) begin req_we = 1'b1; rslot = t_q; req_wdata = MK; end
      ST_C_RD:   if (s_in && s_q != t_q) begin
                   req_re = 1'b1; rslot = s_q; req_exp = BG;
                 end
      ST_C_REST: begin req_we = 1'b1; rslot = t_q; req_wdata = BG; end
      default: ;
    endcase
    req_addr = base_q | slot_off(rslot);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      done       <= 1'b0;
      pass       <= 1'b0;
      fail_stage <= FS_NONE;
      fail_info  <= '0;
      bit_i      <= '0;
      s_q        <= '0;
      t_q        <= '0;
      nb_q       <= '0;
      base_q     <= '0;
    end else begin
      unique case (state)
        ST_IDLE: if (start) begin
          base_q     <= base_addr;
          nb_q       <= (int'(size_lg) > ADDR_W) ? CW'(ADDR_W) : CW'(size_lg);
          done       <= 1'b0;
          pass       <= 1'b0;
          fail_stage <= FS_NONE;
          fail_info  <= '0;
          bit_i      <= '0;
          state      <= ST_D_WR;
        end
        ST_D_WR: state <= ST_D_RD;
        ST_D_RD: state <= ST_D_W1;
        ST_D_W1: state <= ST_D_CMP;
        ST_D_CMP: begin
          if (cmp_bad) begin
            done       <= 1'b1;
            fail_stage <= FS_DATA;
            fail_info  <= IW'(walk_pat);
            state      <= ST_IDLE;
          end else if (bit_i == BW'(DATA_W - 1)) begin
            s_q   <= CW'(1);
            state <= ST_A_FILL;
          end else begin
            bit_i <= bit_i + BW'(1);
            state <= ST_D_WR;
          end
        end
        ST_A_FILL: begin
          if (s_in) s_q <= s_q + CW'(1);
          else begin
            s_q   <= CW'(1);
            state <= ST_A_MARK;
          end
        end
        ST_A_MARK: state <= ST_A_RD;
        ST_A_RD:   state <= s_in ? ST_A_W1 : ST_A_REST;
        ST_A_W1:   state <= ST_A_CMP;
        ST_A_CMP: begin
          if (cmp_bad) begin
            done       <= 1'b1;
            fail_stage <= FS_MARK;
            fail_info  <= IW'(base_q | slot_off(s_q));
            state      <= ST_IDLE;
          end else begin
            s_q   <= s_q + CW'(1);
            state <= ST_A_RD;
          end
        end
        ST_A_REST: begin
          t_q   <= CW'(1);
          state <= ST_C_SET;
        end
        ST_C_SET: begin
          if (t_in) begin
            s_q   <= '0;
            state <= ST_C_RD;
          end else begin
            done  <= 1'b1;
            pass  <= 1'b1;
            state <= ST_IDLE;
          end
        end
        ST_C_RD: begin
          if (!s_in)           state <= ST_C_REST;
          else if (s_q == t_q) s_q   <= s_q + CW'(1);
          else                 state <= ST_C_W1;
        end
        ST_C_W1: state <= ST_C_CMP;
        ST_C_CMP: begin
          if (cmp_bad) begin
            done       <= 1'b1;
            fail_stage <= FS_WALK;
            fail_info  <= IW'(base_q | slot_off(t_q));
            state      <= ST_IDLE;
          end else begin
            s_q   <= s_q + CW'(1);
            state <= ST_C_RD;
          end
        end
        ST_C_REST: begin
          t_q   <= t_q + CW'(1);
          state <= ST_C_SET;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R9: every compare state sees data that the check pipeline marked valid
  p_cmp_aligned_r9: assert property (@(posedge clk) disable iff (rst)
    (state == ST_D_CMP || state == ST_A_CMP || state == ST_C_CMP) |-> cmp_vld);

  // R8: results stay frozen while no start arrives
  p_result_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (done && !start) |=> (done && $stable(pass) && $stable(fail_info)));

  // R8: an accepted start clears done on the next edge
  p_start_clears_r8: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE && start) |=> !done);

  // R7: a pass never carries a failure code
  p_pass_clean_r7: assert property (@(posedge clk) disable iff (rst)
    pass |-> (fail_stage == FS_NONE && fail_info == '0));
endmodule

// File: rtl/membus_wiring_bist.sv
module membus_wiring_bist #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16,
  localparam int SW = $clog2(ADDR_W + 1),
  localparam int IW = (ADDR_W > DATA_W) ? ADDR_W : DATA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [ADDR_W-1:0] base_addr,
  input  logic [SW-1:0]     size_lg,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              mem_we,
  output logic              mem_re,
  output logic              done,
  output logic              pass,
  output logic [1:0]        fail_stage,
  output logic [IW-1:0]     fail_info
);
  import mbt_pkg::*;

  localparam int CW = $clog2(ADDR_W + 2);

  logic              req_we, req_re;
  logic [ADDR_W-1:0] req_addr;
  logic [DATA_W-1:0] req_wdata, req_exp;
  logic              cmp_vld, cmp_bad;
  mbt_stage_e        stage_w;

  mbt_ctrl #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SW(SW), .IW(IW), .CW(CW)
  ) u_ctrl (
    .clk(clk), .rst(rst), .start(start), .base_addr(base_addr),
    .size_lg(size_lg), .cmp_vld(cmp_vld), .cmp_bad(cmp_bad),
    .req_we(req_we), .req_re(req_re), .req_addr(req_addr),
    .req_wdata(req_wdata), .req_exp(req_exp), .done(done), .pass(pass),
    .fail_stage(stage_w), .fail_info(fail_info)
  );

  mbt_port #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_port (
    .clk(clk), .rst(rst), .req_we(req_we), .req_re(req_re),
    .req_addr(req_addr), .req_wdata(req_wdata), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_we(mem_we), .mem_re(mem_re)
  );

  mbt_check #(.DATA_W(DATA_W)) u_check (
    .clk(clk), .rst(rst), .req_re(req_re), .req_exp(req_exp),
    .mem_re(mem_re), .mem_rdata(mem_rdata), .cmp_vld(cmp_vld),
    .cmp_bad(cmp_bad)
  );

  assign fail_stage = stage_w;
endmodule

// File: tb/membus_wiring_bist_tb.sv
module membus_wiring_bist_tb;
  localparam int AW = 8;
  localparam int DW = 8;
  localparam int NV = 13;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start = 1'b0;
  logic [AW-1:0] base_addr = '0;
  logic [3:0]    size_lg = '0;
  logic [DW-1:0] mem_rdata = '0;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata;
  logic          mem_we, mem_re, done, pass;
  logic [1:0]    fail_stage;
  logic [7:0]    fail_info;

  int total = 0;
  int bad = 0;
  int n_off = 0;

  logic [7:0] f_dh = 0, f_dl = 0, f_ah = 0, f_al = 0, f_sh = 0;
  logic [7:0] mem [256];

  always #5 clk = ~clk;

  membus_wiring_bist #(.ADDR_W(AW), .DATA_W(DW)) u_dut (
    .clk(clk), .rst(rst), .start(start), .base_addr(base_addr),
    .size_lg(size_lg), .mem_rdata(mem_rdata), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_we(mem_we), .mem_re(mem_re), .done(done),
    .pass(pass), .fail_stage(fail_stage), .fail_info(fail_info)
  );

  function automatic logic [7:0] eff(input logic [7:0] a, input logic [7:0] ah,
                                     input logic [7:0] al, input logic [7:0] sh);
    logic [7:0] r;
    r = (a | ah) & ~al;
    if ((r & sh) != 0) r = r | sh;
    return r;
  endfunction

  // faulty memory model, one-cycle read latency
  always @(posedge clk) begin
    if (mem_we) mem[eff(mem_addr, f_ah, f_al, f_sh)] <= (mem_wdata | f_dh) & ~f_dl;
    if (mem_re) mem_rdata <= mem[eff(mem_addr, f_ah, f_al, f_sh)];
    if ((mem_we || mem_re) && mem_addr != base_addr) n_off <= n_off + 1;
  end

  // vector table: faults, region, expected result
  localparam logic [7:0] T_DH [NV] = '{0, 0, 8'h01, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0};
  localparam logic [7:0] T_DL [NV] = '{0, 8'h08, 0, 0, 0, 0, 0, 0, 8'h80, 0, 0, 0, 0};
  localparam logic [7:0] T_AH [NV] = '{0, 0, 0, 8'h04, 0, 8'h20, 0, 8'h01, 0, 0, 0, 0, 0};
  localparam logic [7:0] T_AL [NV] = '{0, 0, 0, 0, 8'h02, 0, 0, 0, 0, 8'h08, 0, 0, 0};
  localparam logic [7:0] T_SH [NV] = '{0, 0, 0, 0, 0, 0, 8'h03, 0, 0, 0, 8'h0C, 0, 0};
  localparam logic [7:0] T_BA [NV] = '{8'h40, 8'h40, 8'h40, 8'h40, 8'h40, 8'h40, 8'h40,
                                       8'h80, 8'h40, 8'h40, 8'h40, 8'h00, 8'h00};
  localparam logic [3:0] T_LG [NV] = '{4, 4, 4, 4, 4, 4, 4, 0, 4, 4, 4, 8, 12};
  localparam logic       T_PS [NV] = '{1, 0, 0, 0, 0, 1, 0, 1, 0, 0, 0, 1, 1};
  localparam logic [1:0] T_ST [NV] = '{0, 1, 1, 2, 2, 0, 3, 0, 1, 2, 3, 0, 0};
  localparam logic [7:0] T_FI [NV] = '{0, 8'h08, 8'h02, 8'h44, 8'h42, 0, 8'h41, 0,
                                       8'h80, 8'h48, 8'h44, 0, 0};
  localparam string      T_RQ [NV] = '{"R7", "R2", "R2", "R5", "R5", "R4", "R6", "R4",
                                       "R2", "R5", "R6", "R7", "R4"};

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic pulse_start();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic wait_done(input string req);
    int n = 0;
    while (!done && n < 5000) begin
      @(negedge clk);
      n++;
    end
    if (!done) chk({req, " timeout"}, 0, 1);
  endtask

  task automatic load(input int i);
    @(negedge clk);
    f_dh = T_DH[i]; f_dl = T_DL[i]; f_ah = T_AH[i]; f_al = T_AL[i]; f_sh = T_SH[i];
    base_addr = T_BA[i]; size_lg = T_LG[i];
    n_off = 0;
  endtask

  initial begin
    #(200000 * 10);
    total++;
    bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset values
    chk("R1 done", done, 0);
    chk("R1 pass", pass, 0);
    chk("R1 stage", fail_stage, 0);
    chk("R1 info", fail_info, 0);
    chk("R1 strobes", {mem_we, mem_re}, 0);
    rst = 1'b0;
    repeat (4) @(negedge clk);
    chk("R1 idle strobes", {mem_we, mem_re}, 0);

    for (int i = 0; i < NV; i++) begin
      load(i);
      pulse_start();
      chk("R8 done cleared", done, 0);
      wait_done(T_RQ[i]);
      chk({T_RQ[i], " pass"}, pass, T_PS[i]);
      chk({T_RQ[i], " stage"}, fail_stage, T_ST[i]);
      chk({T_RQ[i], " info"}, fail_info, T_FI[i]);
      if (T_ST[i] == 2'd1) chk("R3 no address phase", n_off, 0);
      if (i == 0) begin
        // R7: background restored across the region
        chk("R7 base bg", mem[8'h40], 8'hAA);
        chk("R7 off1 bg", mem[8'h41], 8'hAA);
        chk("R7 off8 bg", mem[8'h48], 8'hAA);
        // R8: result held while no start
        repeat (30) @(negedge clk);
        chk("R8 held done", done, 1);
        chk("R8 held pass", pass, 1);
      end
    end

    // R8: a start during a run is ignored; R5 fault result must survive it
    load(3);
    pulse_start();
    repeat (10) @(negedge clk);
    base_addr = 8'h00;
    size_lg = 4'd2;
    pulse_start();
    wait_done("R8");
    chk("R8 busy start stage", fail_stage, 2);
    chk("R8 busy start info", fail_info, 8'h44);

    // R9: a read and a write are never seen together on the port
    load(0);
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    begin
      int both = 0;
      while (!done) begin
        if (mem_we && mem_re) both++;
        @(negedge clk);
      end
      chk("R9 exclusive strobes", both, 0);
      chk("R9 pass with latency", pass, 1);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule